// File: doc/BRIEF.md
# Video and Ancillary Output Stream Formatter

This block drains two packet queues, one holding scaled video words and one holding sliced-text words, onto a single output port. The port is 8 or 16 bits wide. A two-bit arbitration field decides which queue may start the next packet. Once a packet has started, it runs to completion.

Each 32-bit word is split into bytes, or into byte pairs in wide mode, with the lowest byte first. Every packet is wrapped in four-byte timing reference codes. The code before the payload is a start code and the code after it is an end code. Text packets may instead open with a four-byte ancillary header and carry no closing code. A qualifier output marks the cycles that carry data, and a second output marks the cycles that carry text. On every other cycle the data lanes are driven to zero. Each queue reports empty, full and a programmable fill-threshold flag, which an upstream producer can use for handshaking.

The sequencer has four named states:
- IDLE waits for a complete packet.
- HDR sends the opening code or header.
- DATA sends the payload words.
- TRL sends the closing code.

It moves through these transitions:
- IDLE goes to HDR when the arbitration picks a queue.
- HDR goes to DATA after the last byte of the header.
- DATA goes to TRL after the final word of the packet, or goes to IDLE if the packet has an ancillary header.
- TRL goes to IDLE after the last byte of the closing code.

Top module: `vid_txt_formatter`

## Requirements
- R1: With `wide_mode`=0, each word leaves as four consecutive valid cycles on `dout[7:0]`, byte 0 (bits 7:0) first, and `dout[15:8]` is 00H on every cycle.
- R2: With `wide_mode`=1, each word leaves in two valid cycles: bits 15:0 first, then bits 31:16. Within each cycle, the lower-numbered byte is on `dout[7:0]`.
- R3: On every cycle with `dq`=0, `dout` is 0000H.
- R4: A video packet is sent as FF,00,00,XY(H=0), then the payload, then FF,00,00,XY(H=1). XY is {1,F,V,H,V^H,F^H,F^V,F^V^H}, with F taken from `fld_id` and V taken from `vblank`, both captured when the packet starts.
- R5: When `txt_anc`=1, a text packet opens with 00,FF,FF,`DID` (default 5AH) and has no closing code. When `txt_anc`=0, it is framed like video but with V forced to 1.
- R6: A payload byte of 00H is sent as 01H, and a payload byte of FFH is sent as FEH. All other payload bytes pass unchanged.
- R7: A packet starts only when its final word (pushed with `*_last`=1) has been stored. With `arb_mode`=00 only video is sent. With `arb_mode`=01 only text is sent, and the other queue stays held.
- R8: With `arb_mode`=10, when both queues hold a complete packet, the text packet goes first.
- R9: With `arb_mode`=11, video goes first, and text is sent only while the video queue is empty.
- R10: A packet's bytes are sent contiguously, with no idle cycle or byte from the other source inside the packet.
- R11: Each queue has these flags: `*_empty` means the level is 0, `*_full` means the level is DEPTH (default 8), and `*_thr_hit` means the level is at least `*_thr`. A push while the queue is full is dropped.
- R12: `txt_mark` is 1 exactly on the valid cycles of a text packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_push | input | 1 | Write a video word |
| vid_word | input | 32 | Video word |
| vid_last | input | 1 | Word ends a video packet |
| txt_push | input | 1 | Write a text word |
| txt_word | input | 32 | Text word |
| txt_last | input | 1 | Word ends a text packet |
| arb_mode | input | 2 | 00 video, 01 text, 10 text first, 11 video first |
| wide_mode | input | 1 | 1 selects 16-bit output |
| txt_anc | input | 1 | 1 selects the ancillary header for text |
| fld_id | input | 1 | Field bit for timing codes |
| vblank | input | 1 | Vertical blanking bit for video codes |
| vid_thr | input | LVLW | Video fill threshold |
| txt_thr | input | LVLW | Text fill threshold |
| dout | output | 16 | Output data lanes |
| dq | output | 1 | Data qualifier |
| txt_mark | output | 1 | Text transfer marker |
| vid_empty | output | 1 | Video queue empty |
| vid_full | output | 1 | Video queue full |
| vid_thr_hit | output | 1 | Video level at or above the threshold |
| txt_empty | output | 1 | Text queue empty |
| txt_full | output | 1 | Text queue full |
| txt_thr_hit | output | 1 | Text level at or above the threshold |

## Verification
The assertions rely on two conditions:
- `wide_mode` and `txt_anc` stay constant while a packet is in flight.
- A pop is only requested on a queue that holds the rest of the current packet, which the whole-packet start rule guarantees.

The stimulus changes mode, width and framing inputs only after the port has drained and sits in IDLE. Packets are held back either by withholding their final word or by choosing an arbitration mode that excludes their source. The bench never relies on a mid-packet stall.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;
    typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_TRL} fmt_state_e;
    typedef enum logic [1:0] {
        ARB_VID     = 2'b00,
        ARB_TXT     = 2'b01,
        ARB_TXT_PRI = 2'b10,
        ARB_VID_PRI = 2'b11
    } arb_mode_e;

    function automatic logic [7:0] trc_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] clip_byte(input logic [7:0] b);
        if (b == 8'h00)      return 8'h01;
        else if (b == 8'hFF) return 8'hFE;
        else                 return b;
    endfunction
endpackage

// File: rtl/ofmt_fifo.sv
module ofmt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [W-1:0]    push_data,
    input  logic            push_last,
    input  logic            pop,
    output logic [W-1:0]    rd_data,
    output logic            rd_last,
    input  logic [LVLW-1:0] thr,
    output logic            empty,
    output logic            full,
    output logic            thr_hit,
    output logic            pkt_avail
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W:0]      mem [DEPTH];
    logic [PW-1:0]   wptr, rptr;
    logic [LVLW-1:0] level, pkts;
    logic            push_ok, pop_ok;

    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign empty   = (level == '0);
    assign full    = (level == LVLW'(DEPTH));
    assign thr_hit = (level >= thr);
    assign pkt_avail = (pkts != '0);
    assign {rd_last, rd_data} = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= {push_last, push_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            pkts  <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            level <= level + LVLW'(push_ok) - LVLW'(pop_ok);
            pkts  <= pkts + LVLW'(push_ok && push_last) - LVLW'(pop_ok && rd_last);
        end
    end

    // R11: a pop never targets an empty queue
    p_pop_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R11: a push into a full queue without a pop leaves it full
    p_drop_on_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    // R11: complete packets never outnumber stored words
    p_pkt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkts <= level);
endmodule

// File: rtl/ofmt_seq.sv
module ofmt_seq
    import ofmt_pkg::*;
#(
    parameter logic [7:0] DID = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  arb_mode,
    input  logic        wide,
    input  logic        txt_anc,
    input  logic        fld,
    input  logic        vblk,
    input  logic [31:0] vid_rd_data,
    input  logic        vid_rd_last,
    input  logic        vid_pkt,
    input  logic        vid_empty,
    output logic        vid_pop,
    input  logic [31:0] txt_rd_data,
    input  logic        txt_rd_last,
    input  logic        txt_pkt,
    output logic        txt_pop,
    output logic [15:0] dout,
    output logic        dvalid,
    output logic        txt_mark
);
    fmt_state_e  state_q, state_n;
    logic        src_q, src_n;
    logic [1:0]  idx_q, idx_n;
    logic        f_q, f_n, v_q, v_n;
    logic        take_vid, take_txt, elem_end, anc_mode, cur_last, pop;
    logic [31:0] word, elem, shifted;

    always_comb begin
        take_vid = 1'b0;
        take_txt = 1'b0;
        unique case (arb_mode_e'(arb_mode))
            ARB_VID:     take_vid = vid_pkt;
            ARB_TXT:     take_txt = txt_pkt;
            ARB_TXT_PRI: begin
                take_txt = txt_pkt;
                take_vid = vid_pkt && !txt_pkt;
            end
            ARB_VID_PRI: begin
                take_vid = vid_pkt;
                take_txt = txt_pkt && vid_empty;
            end
        endcase
    end

    assign elem_end = wide ? (idx_q == 2'd2) : (idx_q == 2'd3);
    assign anc_mode = src_q && txt_anc;
    assign cur_last = src_q ? txt_rd_last : vid_rd_last;
    assign pop      = (state_q == S_DATA) && elem_end;
    assign vid_pop  = pop && !src_q;
    assign txt_pop  = pop && src_q;

    always_comb begin
        word = src_q ? txt_rd_data : vid_rd_data;
        elem = '0;
        unique case (state_q)
            S_IDLE: elem = '0;
            S_HDR:  elem = anc_mode ? {DID, 8'hFF, 8'hFF, 8'h00}
                                    : {trc_xy(f_q, v_q, 1'b0), 8'h00, 8'h00, 8'hFF};
            S_DATA: for (int b = 0; b < 4; b++) elem[b*8 +: 8] = clip_byte(word[b*8 +: 8]);
            S_TRL:  elem = {trc_xy(f_q, v_q, 1'b1), 8'h00, 8'h00, 8'hFF};
        endcase
        shifted = elem >> {idx_q, 3'b000};
    end

    // next-state and transition logic
    always_comb begin
        state_n = state_q;
        src_n   = src_q;
        f_n     = f_q;
        v_n     = v_q;
        idx_n   = (state_q == S_IDLE || elem_end) ? 2'd0 : idx_q + (wide ? 2'd2 : 2'd1);
        unique case (state_q)
            S_IDLE: if (take_txt || take_vid) begin
                state_n = S_HDR;
                src_n   = take_txt;
                f_n     = fld;
                v_n     = take_txt ? 1'b1 : vblk;
            end
            S_HDR:  if (elem_end) state_n = S_DATA;
            S_DATA: if (elem_end && cur_last) state_n = anc_mode ? S_IDLE : S_TRL;
            S_TRL:  if (elem_end) state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            src_q   <= 1'b0;
            idx_q   <= 2'd0;
            f_q     <= 1'b0;
            v_q     <= 1'b0;
        end else begin
            state_q <= state_n;
            src_q   <= src_n;
            idx_q   <= idx_n;
            f_q     <= f_n;
            v_q     <= v_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dvalid   <= 1'b0;
            txt_mark <= 1'b0;
        end else begin
            dvalid   <= (state_q != S_IDLE);
            txt_mark <= (state_q != S_IDLE) && src_q;
            if (state_q == S_IDLE) dout <= '0;
            else                   dout <= {wide ? shifted[15:8] : 8'h00, shifted[7:0]};
        end
    end

    // R3: idle cycles carry zero on both lanes
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid |-> (dout == 16'h0000));
    // R12: the text marker only rides on valid cycles
    p_mark_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        txt_mark |-> dvalid);
    // R10: source of a running packet never changes
    p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> $stable(src_q));
    // R7: payload pops only come from a queue holding a complete packet
    p_pop_in_pkt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_pop |-> vid_pkt) and (txt_pop |-> txt_pkt));
endmodule

// File: rtl/vid_txt_formatter.sv
module vid_txt_formatter #(
    parameter int          DEPTH = 8,
    parameter logic [7:0]  DID   = 8'h5A,
    localparam int         LVLW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vid_push,
    input  logic [31:0]     vid_word,
    input  logic            vid_last,
    input  logic            txt_push,
    input  logic [31:0]     txt_word,
    input  logic            txt_last,
    input  logic [1:0]      arb_mode,
    input  logic            wide_mode,
    input  logic            txt_anc,
    input  logic            fld_id,
    input  logic            vblank,
    input  logic [LVLW-1:0] vid_thr,
    input  logic [LVLW-1:0] txt_thr,
    output logic [15:0]     dout,
    output logic            dq,
    output logic            txt_mark,
    output logic            vid_empty,
    output logic            vid_full,
    output logic            vid_thr_hit,
    output logic            txt_empty,
    output logic            txt_full,
    output logic            txt_thr_hit
);
    logic [31:0] vid_rd, txt_rd;
    logic        vid_rl, txt_rl, vid_pkt, txt_pkt, vid_pop, txt_pop;

    ofmt_fifo #(.W(32), .DEPTH(DEPTH)) u_vid_q (
        .clk(clk), .rst_n(rst_n), .push(vid_push), .push_data(vid_word),
        .push_last(vid_last), .pop(vid_pop), .rd_data(vid_rd), .rd_last(vid_rl),
        .thr(vid_thr), .empty(vid_empty), .full(vid_full), .thr_hit(vid_thr_hit),
        .pkt_avail(vid_pkt)
    );

    ofmt_fifo #(.W(32), .DEPTH(DEPTH)) u_txt_q (
        .clk(clk), .rst_n(rst_n), .push(txt_push), .push_data(txt_word),
        .push_last(txt_last), .pop(txt_pop), .rd_data(txt_rd), .rd_last(txt_rl),
        .thr(txt_thr), .empty(txt_empty), .full(txt_full), .thr_hit(txt_thr_hit),
        .pkt_avail(txt_pkt)
    );

    ofmt_seq #(.DID(DID)) u_seq (
        .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .wide(wide_mode),
        .txt_anc(txt_anc), .fld(fld_id), .vblk(vblank),
        .vid_rd_data(vid_rd), .vid_rd_last(vid_rl), .vid_pkt(vid_pkt),
        .vid_empty(vid_empty), .vid_pop(vid_pop),
        .txt_rd_data(txt_rd), .txt_rd_last(txt_rl), .txt_pkt(txt_pkt),
        .txt_pop(txt_pop), .dout(dout), .dvalid(dq), .txt_mark(txt_mark)
    );
endmodule

// File: tb/vid_txt_formatter_tb_top.sv
module vid_txt_formatter_tb_top;
    localparam int DEPTH = 8;
    localparam int LVLW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vid_push = 0, vid_last = 0, txt_push = 0, txt_last = 0;
    logic [31:0] vid_word = '0, txt_word = '0;
    logic [1:0] arb_mode = 2'b00;
    logic wide_mode = 0, txt_anc = 0, fld_id = 0, vblank = 0;
    logic [LVLW-1:0] vid_thr = 4'd3, txt_thr = 4'd3;
    logic [15:0] dout;
    logic dq, txt_mark, vid_empty, vid_full, vid_thr_hit, txt_empty, txt_full, txt_thr_hit;

    always #2 clk = ~clk;

    vid_txt_formatter #(.DEPTH(DEPTH)) dut_i (.*);

    int n_cmp = 0, n_bad = 0;
    logic [7:0] cap_b [256];
    logic       cap_m [256];
    logic [7:0] exp_b [256];
    logic       exp_m [256];
    int ncap = 0, nexp = 0, idle_bad = 0, upper_bad = 0, mark_bad = 0;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (dq) begin
            if (ncap < 256) begin cap_b[ncap] = dout[7:0]; cap_m[ncap] = txt_mark; end
            ncap++;
            if (wide_mode) begin
                if (ncap < 256) begin cap_b[ncap] = dout[15:8]; cap_m[ncap] = txt_mark; end
                ncap++;
            end else if (dout[15:8] != 8'h00) upper_bad++;
        end else begin
            if (dout != 16'h0000) idle_bad++;
            if (txt_mark) mark_bad++;
        end
    end

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] clipb(input logic [7:0] b);
        return (b == 8'h00) ? 8'h01 : (b == 8'hFF) ? 8'hFE : b;
    endfunction

    task automatic ex_byte(input logic [7:0] b, input logic m);
        exp_b[nexp] = b; exp_m[nexp] = m; nexp++;
    endtask
    task automatic ex_code(input logic f, input logic v, input logic h, input logic m);
        ex_byte(8'hFF, m); ex_byte(8'h00, m); ex_byte(8'h00, m); ex_byte(xy(f, v, h), m);
    endtask
    task automatic ex_word(input logic [31:0] w, input logic m);
        for (int b = 0; b < 4; b++) ex_byte(clipb(w[b*8 +: 8]), m);
    endtask

    task automatic clear_streams();
        ncap = 0; nexp = 0; idle_bad = 0; upper_bad = 0; mark_bad = 0;
    endtask

    task automatic compare(string req);
        check({req, " length"}, ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++) begin
            check({req, " byte"}, cap_b[i], exp_b[i]);
            check({req, " marker R12"}, cap_m[i], exp_m[i]);
        end
        check({req, " idle lanes R3"}, idle_bad, 0);
        check({req, " upper lane R1"}, upper_bad, 0);
        check({req, " idle marker R12"}, mark_bad, 0);
    endtask

    task automatic push_v(input logic [31:0] w, input logic l);
        @(negedge clk); vid_push = 1; vid_word = w; vid_last = l;
        @(negedge clk); vid_push = 0; vid_last = 0;
    endtask
    task automatic push_t(input logic [31:0] w, input logic l);
        @(negedge clk); txt_push = 1; txt_word = w; txt_last = l;
        @(negedge clk); txt_push = 0; txt_last = 0;
    endtask
    task automatic push_both_last(input logic [31:0] wv, input logic [31:0] wt);
        @(negedge clk);
        vid_push = 1; vid_word = wv; vid_last = 1;
        txt_push = 1; txt_word = wt; txt_last = 1;
        @(negedge clk);
        vid_push = 0; vid_last = 0; txt_push = 0; txt_last = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R3 reset dq", dq, 0);
        check("R3 reset dout", dout, 0);
        check("R12 reset mark", txt_mark, 0);
        check("R11 reset vid_empty", vid_empty, 1);
        check("R11 reset vid_full", vid_full, 0);
        check("R11 reset txt_empty", txt_empty, 1);
    endtask

    task automatic t_video8();
        arb_mode = 2'b00; wide_mode = 0; fld_id = 1; vblank = 0;
        clear_streams();
        push_v(32'h44332211, 0);
        push_v(32'h88776655, 1);
        idle(40);
        ex_code(1, 0, 0, 0); ex_word(32'h44332211, 0); ex_word(32'h88776655, 0); ex_code(1, 0, 1, 0);
        compare("R1 video 8-bit");
        check("R4 start code XY", cap_b[3], 8'hC7);
        check("R4 end code XY", cap_b[15], 8'hDA);
    endtask

    task automatic t_video16();
        arb_mode = 2'b00; wide_mode = 1; fld_id = 0; vblank = 1;
        clear_streams();
        push_v(32'hA1B2C3D4, 1);
        idle(30);
        ex_code(0, 1, 0, 0); ex_word(32'hA1B2C3D4, 0); ex_code(0, 1, 1, 0);
        compare("R2 video 16-bit");
        wide_mode = 0;
    endtask

    task automatic t_clip();
        arb_mode = 2'b00; fld_id = 0; vblank = 0;
        clear_streams();
        push_v(32'h00FF7F80, 1);
        idle(30);
        ex_code(0, 0, 0, 0); ex_word(32'h00FF7F80, 0); ex_code(0, 0, 1, 0);
        compare("R6 clip");
        check("R6 FF clipped", cap_b[6], 8'hFE);
        check("R6 00 clipped", cap_b[7], 8'h01);
    endtask

    task automatic t_text_anc();
        arb_mode = 2'b01; txt_anc = 1;
        clear_streams();
        push_t(32'h12345678, 1);
        idle(30);
        ex_byte(8'h00, 1); ex_byte(8'hFF, 1); ex_byte(8'hFF, 1); ex_byte(8'h5A, 1);
        ex_word(32'h12345678, 1);
        compare("R5 text ancillary header");
    endtask

    task automatic t_text_sav();
        arb_mode = 2'b01; txt_anc = 0; fld_id = 0;
        clear_streams();
        push_t(32'hCAFE0001, 1);
        idle(30);
        ex_code(0, 1, 0, 1); ex_word(32'hCAFE0001, 1); ex_code(0, 1, 1, 1);
        compare("R5 text timing codes");
    endtask

    task automatic t_exclusive();
        arb_mode = 2'b00; txt_anc = 0; fld_id = 1; vblank = 0;
        clear_streams();
        push_t(32'h0A0B0C0D, 1);
        idle(30);
        check("R7 text held in video mode", ncap, 0);
        check("R7 text queue kept", txt_empty, 0);
        arb_mode = 2'b01;
        idle(30);
        ex_code(1, 1, 0, 1); ex_word(32'h0A0B0C0D, 1); ex_code(1, 1, 1, 1);
        compare("R7 text released");
        clear_streams();
        push_v(32'h01020304, 1);
        idle(30);
        check("R7 video held in text mode", ncap, 0);
        check("R7 video queue kept", vid_empty, 0);
        arb_mode = 2'b00;
        idle(30);
        ex_code(1, 0, 0, 0); ex_word(32'h01020304, 0); ex_code(1, 0, 1, 0);
        compare("R7 video released");
    endtask

    task automatic t_priority(input logic [1:0] mode, string req);
        arb_mode = mode; txt_anc = 0; fld_id = 0; vblank = 0;
        clear_streams();
        push_v(32'h11111111, 0);
        push_t(32'h22222222, 0);
        push_both_last(32'h33333333, 32'h44444444);
        idle(80);
        if (mode == 2'b10) begin
            ex_code(0, 1, 0, 1); ex_word(32'h22222222, 1); ex_word(32'h44444444, 1); ex_code(0, 1, 1, 1);
            ex_code(0, 0, 0, 0); ex_word(32'h11111111, 0); ex_word(32'h33333333, 0); ex_code(0, 0, 1, 0);
        end else begin
            ex_code(0, 0, 0, 0); ex_word(32'h11111111, 0); ex_word(32'h33333333, 0); ex_code(0, 0, 1, 0);
            ex_code(0, 1, 0, 1); ex_word(32'h22222222, 1); ex_word(32'h44444444, 1); ex_code(0, 1, 1, 1);
        end
        compare({req, " order, contiguous R10"});
    endtask

    task automatic t_flags();
        arb_mode = 2'b01; fld_id = 0; vblank = 0; vid_thr = 4'd3;
        clear_streams();
        push_v(32'h50505051, 1);
        push_v(32'h50505052, 1);
        check("R11 below threshold", vid_thr_hit, 0);
        push_v(32'h50505053, 1);
        check("R11 at threshold", vid_thr_hit, 1);
        check("R11 not empty", vid_empty, 0);
        for (int i = 4; i <= DEPTH; i++) push_v(32'h50505050 + i, 1);
        check("R11 full", vid_full, 1);
        push_v(32'hDEADBEEF, 1);
        check("R11 still full", vid_full, 1);
        arb_mode = 2'b00;
        idle(DEPTH * 16 + 20);
        for (int i = 1; i <= DEPTH; i++) begin
            ex_code(0, 0, 0, 0); ex_word(32'h50505050 + i, 0); ex_code(0, 0, 1, 0);
        end
        compare("R11 overflow dropped");
        check("R11 drained empty", vid_empty, 1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_video8();
        t_video16();
        t_clip();
        t_text_anc();
        t_text_sav();
        t_exclusive();
        t_priority(2'b10, "R8 text first");
        t_priority(2'b11, "R9 video first");
        t_flags();
        finish_run();
    end
endmodule